// File: doc/BRIEF.md
# Memory-Mapped Working Register File with Pointer Pairs

This block holds the thirty-two byte-wide working registers of a small 8-bit processor core. The core reaches them by register number through two combinational read ports and one write port. The same registers also sit at the bottom of a unified 16-bit data address space. A data-bus slave port decodes that space into four regions: the register file, a 64-location I/O window, an unmapped gap, and general SRAM. The I/O window and the SRAM region are handed to outside logic through select strobes.

The six highest registers pair up into three 16-bit address pointers, called X, Y and Z. Each pointer is visible on its own output. A pointer-update input selects one pointer and either post-increments or pre-decrements it as one 16-bit operation in a single cycle. At the same time the block presents the effective address for the indirect access. A write issued in immediate mode is checked against the legal target range. An illegal target raises an error and is dropped.

Top module: `mmrf_top`

## Requirements
- R1: Thirty-two 8-bit registers. `rd_a_data` and `rd_b_data` show the register named by `rd_a_idx` and `rd_b_idx` in the same cycle. A write with `wr_en` high stores `wr_data` into `wr_idx` at the clock edge.
- R2: With `bus_en` high, data addresses 0x0000 to 0x001F map onto registers 0 to 31. `bus_rdata` returns that register. With `bus_we` high, `bus_wdata` is stored into it at the edge.
- R3: Addresses 0x0020 to 0x005F form the I/O window. In this window `io_sel` is 1, `io_addr` is the address minus 0x20, `io_we` follows `bus_we` and `bus_rdata` equals `io_rdata`. No register changes.
- R4: Addresses 0x0100 and above go to SRAM. In this region `sram_sel` is 1, `sram_we` follows `bus_we` and `bus_rdata` equals `sram_rdata`.
- R5: Addresses 0x0060 to 0x00FF are unmapped. In this range `bus_rdata` is 0, both selects stay 0 and a write changes no register.
- R6: The pointer outputs are `ptr_x` = {r27,r26}, `ptr_y` = {r29,r28} and `ptr_z` = {r31,r30}, with the high byte in the odd register.
- R7: With `imm_mode` and `wr_en` high, a `wr_idx` below 16 sets `imm_err` to 1 and the write is discarded. A `wr_idx` of 16 to 31 writes normally with `imm_err` at 0.
- R8: `ptr_sel` chooses the pointer: 0 for X, 1 for Y, 2 for Z, 3 for none. When `ptr_op` is 1 (post-increment), `ptr_addr` shows the current pointer value and the pointer becomes value+1 at the edge. The carry crosses bytes, so 0x00FF becomes 0x0100 and 0xFFFF wraps to 0x0000.
- R9: When `ptr_op` is 2 (pre-decrement), `ptr_addr` shows value-1 and the pointer becomes value-1 at the edge, so 0x0100 becomes 0x00FF. A `ptr_op` of 0 or 3 leaves the pointers unchanged.
- R10: When writers hit the same register in one cycle, the register-port write wins over a pointer update, and a pointer update wins over a data-bus write. Writes to different registers all take effect.
- R11: There is no write-through. A read port addressing a register that is being written shows the old value until the edge.
- R12: Synchronous active-high `rst` clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Register-port write enable |
| wr_idx | input | 5 | Register-port write number |
| wr_data | input | 8 | Register-port write data |
| imm_mode | input | 1 | Current write comes from an immediate-form operation |
| imm_err | output | 1 | Illegal immediate target |
| bus_en | input | 1 | Data-bus access valid |
| bus_we | input | 1 | Data-bus write |
| bus_addr | input | 16 | Data-space address |
| bus_wdata | input | 8 | Data-bus write data |
| bus_rdata | output | 8 | Data-bus read data |
| io_sel | output | 1 | Access falls in the I/O window |
| io_we | output | 1 | I/O write strobe |
| io_addr | output | 6 | Offset within the I/O window |
| io_rdata | input | 8 | Read data from I/O logic |
| sram_sel | output | 1 | Access falls in SRAM |
| sram_we | output | 1 | SRAM write strobe |
| sram_rdata | input | 8 | Read data from SRAM |
| ptr_sel | input | 2 | Pointer select (0 X, 1 Y, 2 Z, 3 none) |
| ptr_op | input | 2 | Pointer operation (0 hold, 1 post-increment, 2 pre-decrement) |
| ptr_addr | output | 16 | Effective address of the indirect access |
| ptr_x | output | 16 | Pointer X |
| ptr_y | output | 16 | Pointer Y |
| ptr_z | output | 16 | Pointer Z |

## Verification
Two sets of collisions can fall in one cycle. The first is a register-port write and a data-bus write to the same register. The second is a pointer update and a register-port write to one byte of that pointer. The bench drives both writers in the same cycle. It then reads the target back through the read port or the pointer output and expects the value the priority rule gives: the port data alone for the first case, and the incremented high byte with the port-written low byte for the second. A companion case aims the two writes at different registers and expects both values to land.

// File: rtl/mmrf_pkg.sv
package mmrf_pkg;
    localparam int DW        = 8;
    localparam int NREG      = 32;
    localparam int IW        = $clog2(NREG);
    localparam int AW        = 16;
    localparam int PW        = 2 * DW;
    localparam int NPTR      = 3;
    localparam int PTR_BASE  = NREG - 2 * NPTR;
    localparam int IMM_MIN   = NREG / 2;
    localparam int IO_SIZE   = 64;
    localparam int IOW       = $clog2(IO_SIZE);
    localparam int SRAM_BASE = 'h100;

    typedef logic [DW-1:0] byte_t;
    typedef logic [IW-1:0] idx_t;
    typedef logic [AW-1:0] addr_t;
    typedef logic [PW-1:0] ptr_t;
    typedef logic [IOW-1:0] io_off_t;

    localparam addr_t IO_LO  = addr_t'(NREG);
    localparam addr_t IO_HI  = addr_t'(NREG + IO_SIZE);
    localparam addr_t SRAM_LO = addr_t'(SRAM_BASE);

    typedef enum logic [1:0] {SEL_X = 2'd0, SEL_Y = 2'd1, SEL_Z = 2'd2, SEL_NONE = 2'd3} ptr_sel_e;
    typedef enum logic [1:0] {OP_HOLD = 2'd0, OP_POSTINC = 2'd1, OP_PREDEC = 2'd2, OP_RSVD = 2'd3} ptr_op_e;
    typedef enum logic [1:0] {RG_FILE, RG_IO, RG_GAP, RG_SRAM} region_e;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        byte_t data;
    } wr_req_t;

    typedef struct packed {
        logic en;
        idx_t lo_idx;
        ptr_t val;
    } ptr_upd_t;

    function automatic region_e classify(addr_t a);
        if (a < IO_LO)        return RG_FILE;
        else if (a < IO_HI)   return RG_IO;
        else if (a < SRAM_LO) return RG_GAP;
        else                  return RG_SRAM;
    endfunction
endpackage

// File: rtl/mmrf_dec.sv
module mmrf_dec
    import mmrf_pkg::*;
(
    input  logic    bus_en,
    input  logic    bus_we,
    input  addr_t   bus_addr,
    input  byte_t   bus_wdata,
    output region_e region,
    output logic    io_sel,
    output logic    io_we,
    output io_off_t io_addr,
    output logic    sram_sel,
    output logic    sram_we,
    output wr_req_t rf_wr
);
    addr_t io_rel;

    always_comb begin
        region   = classify(bus_addr);
        io_rel   = bus_addr - IO_LO;
        io_sel   = bus_en && (region == RG_IO);
        io_we    = io_sel && bus_we;
        io_addr  = io_rel[IOW-1:0];
        sram_sel = bus_en && (region == RG_SRAM);
        sram_we  = sram_sel && bus_we;
        rf_wr.en   = bus_en && bus_we && (region == RG_FILE);
        rf_wr.idx  = bus_addr[IW-1:0];
        rf_wr.data = bus_wdata;
    end
endmodule

// File: rtl/mmrf_ptr.sv
module mmrf_ptr
    import mmrf_pkg::*;
(
    input  ptr_t [NPTR-1:0] cur,
    input  ptr_sel_e        sel,
    input  ptr_op_e         op,
    output ptr_t            eff_addr,
    output ptr_upd_t        upd
);
    ptr_t picked;
    ptr_t next_up;
    ptr_t next_dn;
    logic active;

    always_comb begin
        picked  = '0;
        for (int k = 0; k < NPTR; k++) begin
            if (sel == ptr_sel_e'(k)) picked = cur[k];
        end
        next_up = picked + ptr_t'(1);
        next_dn = picked - ptr_t'(1);
        active  = (sel != SEL_NONE) && ((op == OP_POSTINC) || (op == OP_PREDEC));

        eff_addr   = (op == OP_PREDEC) ? next_dn : picked;
        upd.en     = active;
        upd.lo_idx = idx_t'(PTR_BASE + 2 * int'(sel));
        upd.val    = (op == OP_PREDEC) ? next_dn : next_up;
    end
endmodule

// File: rtl/mmrf_regs.sv
module mmrf_regs
    import mmrf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  wr_req_t             port_wr,
    input  ptr_upd_t            ptr_wr,
    input  wr_req_t             bus_wr,
    output byte_t [NREG-1:0]    q
);
    idx_t hi_idx;
    assign hi_idx = ptr_wr.lo_idx + idx_t'(1);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        byte_t r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (port_wr.en && port_wr.idx == idx_t'(i))
                r <= port_wr.data;
            else if (ptr_wr.en && ptr_wr.lo_idx == idx_t'(i))
                r <= ptr_wr.val[DW-1:0];
            else if (ptr_wr.en && hi_idx == idx_t'(i))
                r <= ptr_wr.val[PW-1:DW];
            else if (bus_wr.en && bus_wr.idx == idx_t'(i))
                r <= bus_wr.data;
        end
        assign q[i] = r;
    end
endmodule

// File: rtl/mmrf_top.sv
module mmrf_top
    import mmrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_a_idx,
    output logic [7:0]  rd_a_data,
    input  logic [4:0]  rd_b_idx,
    output logic [7:0]  rd_b_data,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic [7:0]  wr_data,
    input  logic        imm_mode,
    output logic        imm_err,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        io_sel,
    output logic        io_we,
    output logic [5:0]  io_addr,
    input  logic [7:0]  io_rdata,
    output logic        sram_sel,
    output logic        sram_we,
    input  logic [7:0]  sram_rdata,
    input  logic [1:0]  ptr_sel,
    input  logic [1:0]  ptr_op,
    output logic [15:0] ptr_addr,
    output logic [15:0] ptr_x,
    output logic [15:0] ptr_y,
    output logic [15:0] ptr_z
);
    byte_t [NREG-1:0] q;
    ptr_t  [NPTR-1:0] ptrs;
    wr_req_t  port_wr;
    wr_req_t  bus_wr;
    ptr_upd_t ptr_wr;
    region_e  region;
    logic     low_target;

    always_comb begin
        low_target   = wr_idx < idx_t'(IMM_MIN);
        imm_err      = wr_en && imm_mode && low_target;
        port_wr.en   = wr_en && !(imm_mode && low_target);
        port_wr.idx  = wr_idx;
        port_wr.data = wr_data;
    end

    mmrf_dec u_dec (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .region   (region),
        .io_sel   (io_sel),
        .io_we    (io_we),
        .io_addr  (io_addr),
        .sram_sel (sram_sel),
        .sram_we  (sram_we),
        .rf_wr    (bus_wr)
    );

    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
        assign ptrs[k] = {q[PTR_BASE + 2*k + 1], q[PTR_BASE + 2*k]};
    end

    mmrf_ptr u_ptr (
        .cur     (ptrs),
        .sel     (ptr_sel_e'(ptr_sel)),
        .op      (ptr_op_e'(ptr_op)),
        .eff_addr(ptr_addr),
        .upd     (ptr_wr)
    );

    mmrf_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .port_wr(port_wr),
        .ptr_wr (ptr_wr),
        .bus_wr (bus_wr),
        .q      (q)
    );

    assign rd_a_data = q[rd_a_idx];
    assign rd_b_data = q[rd_b_idx];
    assign ptr_x     = ptrs[0];
    assign ptr_y     = ptrs[1];
    assign ptr_z     = ptrs[2];

    always_comb begin
        bus_rdata = '0;
        if (bus_en) begin
            unique case (region)
                RG_FILE: bus_rdata = q[bus_addr[IW-1:0]];
                RG_IO:   bus_rdata = io_rdata;
                RG_SRAM: bus_rdata = sram_rdata;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mmrf_chk.sv
module mmrf_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic        imm_mode,
    input logic        imm_err,
    input logic        bus_en,
    input logic        bus_we,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_rdata,
    input logic        io_sel,
    input logic [7:0]  io_rdata,
    input logic        sram_sel,
    input logic [7:0]  sram_rdata,
    input logic [1:0]  ptr_sel,
    input logic [1:0]  ptr_op,
    input logic [15:0] ptr_x,
    input logic [15:0] ptr_y,
    input logic [15:0] ptr_z
);
    logic bus_rf_wr;
    assign bus_rf_wr = bus_en && bus_we && (bus_addr < 16'h0020);

    assert_io_window_R3: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> (bus_addr >= 16'h0020 && bus_addr < 16'h0060 && bus_rdata == io_rdata));

    assert_sram_region_R4: assert property (@(posedge clk) disable iff (rst)
        sram_sel |-> (bus_addr >= 16'h0100 && bus_rdata == sram_rdata));

    assert_gap_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_addr >= 16'h0060 && bus_addr < 16'h0100)
            |-> (bus_rdata == 8'h00 && !io_sel && !sram_sel));

    assert_imm_low_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && imm_mode && wr_idx < 5'd16) |-> imm_err);

    assert_postinc_x_R8: assert property (@(posedge clk) disable iff (rst)
        (ptr_op == 2'd1 && ptr_sel == 2'd0 && !wr_en && !bus_rf_wr)
            |=> (ptr_x == $past(ptr_x) + 16'd1));

    assert_predec_y_R9: assert property (@(posedge clk) disable iff (rst)
        (ptr_op == 2'd2 && ptr_sel == 2'd1 && !wr_en && !bus_rf_wr)
            |=> (ptr_y == $past(ptr_y) - 16'd1));

    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (ptr_x == 16'h0 && ptr_y == 16'h0 && ptr_z == 16'h0));
endmodule

bind mmrf_top mmrf_chk u_chk (.*);

// File: tb/tb_mmrf_top.sv
module tb_mmrf_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [7:0]  rd_a_data, rd_b_data, wr_data;
    logic        wr_en, imm_mode, imm_err;
    logic        bus_en, bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata, io_rdata, sram_rdata;
    logic        io_sel, io_we, sram_sel, sram_we;
    logic [5:0]  io_addr;
    logic [1:0]  ptr_sel, ptr_op;
    logic [15:0] ptr_addr, ptr_x, ptr_y, ptr_z;

    always #5 clk = ~clk;

    mmrf_top dut (.*);

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    function automatic logic [15:0] observe(int sel);
        case (sel)
            0:  return {8'h0, rd_a_data};
            1:  return {8'h0, rd_b_data};
            2:  return {8'h0, bus_rdata};
            3:  return ptr_x;
            4:  return ptr_y;
            5:  return ptr_z;
            6:  return ptr_addr;
            7:  return {15'h0, imm_err};
            8:  return {15'h0, io_sel};
            9:  return {10'h0, io_addr};
            10: return {15'h0, sram_sel};
            11: return {15'h0, io_we};
            12: return {15'h0, sram_we};
            default: return 16'hDEAD;
        endcase
    endfunction

    initial begin : monitor
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] got;
                it  = q.pop_front();
                got = observe(it.sel);
                n_tests++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: signal %0d got %h expected %h", it.req, it.sel, got, it.exp);
                end
            end
        end
    end

    task automatic expect_val(int sel, logic [15:0] exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic settle();
        #2;
        -> sample_ev;
        wait (q.size() == 0);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        wr_en = 0; imm_mode = 0; bus_en = 0; bus_we = 0; ptr_op = 2'd0; ptr_sel = 2'd3;
    endtask

    task automatic port_write(input logic [4:0] idx, input logic [7:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic read_a(input logic [4:0] idx, input logic [7:0] exp, input string req);
        rd_a_idx = idx;
        expect_val(0, {8'h0, exp}, req);
        settle();
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        rst = 1; rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        bus_addr = 0; bus_wdata = 0; io_rdata = 8'h5A; sram_rdata = 8'hC3;
        clr();
        repeat (2) @(negedge clk);
        rst = 0;

        // R12: reset state
        expect_val(3, 16'h0, "R12"); expect_val(4, 16'h0, "R12"); expect_val(5, 16'h0, "R12");
        settle();
        read_a(5'd5, 8'h00, "R12");
        bus_en = 1; bus_addr = 16'h0003; expect_val(2, 16'h0, "R12"); settle(); clr();

        // R1: port writes and two read ports
        port_write(5'd5, 8'hA5);
        port_write(5'd20, 8'h3C);
        rd_a_idx = 5'd5; rd_b_idx = 5'd20;
        expect_val(0, 16'h00A5, "R1"); expect_val(1, 16'h003C, "R1"); settle();

        // R11: no write-through
        rd_a_idx = 5'd7; wr_en = 1; wr_idx = 5'd7; wr_data = 8'h11;
        expect_val(0, 16'h0000, "R11"); settle();
        tick(); clr();
        expect_val(0, 16'h0011, "R11"); settle();

        // R2: data-bus access to register file
        bus_en = 1; bus_we = 1; bus_addr = 16'h0009; bus_wdata = 8'h77;
        tick(); clr();
        read_a(5'd9, 8'h77, "R2");
        bus_en = 1; bus_addr = 16'h0014; expect_val(2, 16'h003C, "R2"); settle(); clr();

        // R3: I/O window
        bus_en = 1; bus_we = 1; bus_addr = 16'h0025; bus_wdata = 8'hF0;
        expect_val(8, 16'h1, "R3"); expect_val(9, 16'h5, "R3");
        expect_val(11, 16'h1, "R3"); expect_val(2, 16'h005A, "R3"); settle();
        tick(); clr();
        read_a(5'd5, 8'hA5, "R3");
        bus_en = 1; bus_addr = 16'h005F; expect_val(9, 16'h3F, "R3"); expect_val(8, 16'h1, "R3"); settle(); clr();

        // R5: unmapped gap
        bus_en = 1; bus_we = 1; bus_addr = 16'h0060; bus_wdata = 8'hEE;
        expect_val(2, 16'h0, "R5"); expect_val(8, 16'h0, "R5"); expect_val(10, 16'h0, "R5"); settle();
        tick();
        bus_addr = 16'h00FF;
        expect_val(2, 16'h0, "R5"); expect_val(10, 16'h0, "R5"); settle();
        tick(); clr();
        read_a(5'd0, 8'h00, "R5");
        read_a(5'd31, 8'h00, "R5");

        // R4: SRAM region
        bus_en = 1; bus_we = 1; bus_addr = 16'h0100;
        expect_val(10, 16'h1, "R4"); expect_val(12, 16'h1, "R4");
        expect_val(2, 16'h00C3, "R4"); expect_val(8, 16'h0, "R4"); settle(); clr();

        // R6: pointer composition
        port_write(5'd26, 8'hFF); port_write(5'd27, 8'h00);
        port_write(5'd28, 8'h00); port_write(5'd29, 8'h01);
        port_write(5'd30, 8'hFF); port_write(5'd31, 8'hFF);
        expect_val(3, 16'h00FF, "R6"); expect_val(4, 16'h0100, "R6"); expect_val(5, 16'hFFFF, "R6");
        settle();

        // R8: post-increment with byte carry and wrap
        ptr_sel = 2'd0; ptr_op = 2'd1;
        expect_val(6, 16'h00FF, "R8"); settle();
        tick(); clr();
        expect_val(3, 16'h0100, "R8"); settle();
        ptr_sel = 2'd2; ptr_op = 2'd1;
        expect_val(6, 16'hFFFF, "R8"); settle();
        tick(); clr();
        expect_val(5, 16'h0000, "R8"); settle();

        // R9: pre-decrement with borrow, and hold/none ops
        ptr_sel = 2'd1; ptr_op = 2'd2;
        expect_val(6, 16'h00FF, "R9"); settle();
        tick(); clr();
        expect_val(4, 16'h00FF, "R9"); settle();
        ptr_sel = 2'd3; ptr_op = 2'd1; tick();
        ptr_sel = 2'd0; ptr_op = 2'd3; tick(); clr();
        expect_val(3, 16'h0100, "R9"); expect_val(4, 16'h00FF, "R9"); expect_val(5, 16'h0000, "R9");
        settle();

        // R7: immediate-mode target check
        imm_mode = 1; wr_en = 1; wr_idx = 5'd3; wr_data = 8'h99;
        expect_val(7, 16'h1, "R7"); settle();
        tick(); clr();
        read_a(5'd3, 8'h00, "R7");
        imm_mode = 1; wr_en = 1; wr_idx = 5'd16; wr_data = 8'h42;
        expect_val(7, 16'h0, "R7"); settle();
        tick(); clr();
        read_a(5'd16, 8'h42, "R7");

        // R10: write collisions
        wr_en = 1; wr_idx = 5'd12; wr_data = 8'h12;
        bus_en = 1; bus_we = 1; bus_addr = 16'h000C; bus_wdata = 8'h34;
        tick(); clr();
        read_a(5'd12, 8'h12, "R10");
        wr_en = 1; wr_idx = 5'd13; wr_data = 8'h55;
        bus_en = 1; bus_we = 1; bus_addr = 16'h000E; bus_wdata = 8'h66;
        tick(); clr();
        read_a(5'd13, 8'h55, "R10");
        read_a(5'd14, 8'h66, "R10");
        ptr_sel = 2'd0; ptr_op = 2'd1; wr_en = 1; wr_idx = 5'd26; wr_data = 8'h80;
        tick(); clr();
        expect_val(3, 16'h0180, "R10"); settle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule